// File: doc/BRIEF.md
# PLL Frequency Range Monitor

This block watches the recovered clock of a phase-locked loop and reports when its frequency leaves a band around the 125 MHz reference. It counts VCO edges in the VCO domain with a free-running Gray-coded counter. The reference domain synchronizes that counter and, once per measurement window of reference cycles, takes the difference between two samples. The difference is the number of VCO edges in the window. If it falls below a low limit or rises above a high limit, the bad-frequency flag is raised.

Two controls force the flag low: a sense-disable input, and an input that reports a reset of the PLL loop filter. While either one is active, the window is held at its start. After both are released, the first window is thrown away, because its starting sample was taken while the block was held. The flag is registered, changes only at window boundaries, and resets to 0. One instance is used for each PLL that needs supervision.

With the default parameters, a window is 1024 reference cycles. The low limit is 1000 counts (about 122 MHz) and the high limit is 1048 counts (about 128 MHz).

Top module: `pll_freq_monitor`

## Requirements
- R1: While `rst_n` is low, `freq_bad` is 0. After reset is released, `freq_bad` stays 0 until at least 2*WIN_CYC reference cycles have elapsed, because the first window is discarded.
- R2: When a full window counts fewer than LO_LIM VCO edges (default 1000 per 1024 reference cycles), `freq_bad` is 1 after that window ends.
- R3: When a full window counts more than HI_LIM VCO edges (default 1048 per 1024 reference cycles), `freq_bad` is 1 after that window ends.
- R4: When a full window counts from LO_LIM to HI_LIM edges inclusive, `freq_bad` is 0 after that window ends.
- R5: When `sense_off` is 1 at a reference clock edge, `freq_bad` is 0 after that edge, and it remains 0 for as long as `sense_off` stays 1.
- R6: When `filt_rst` is 1 at a reference clock edge, `freq_bad` is 0 after that edge, and it remains 0 for as long as `filt_rst` stays 1.
- R7: When neither control is active, `freq_bad` changes only at window ends. Two successive changes are therefore at least WIN_CYC-1 reference cycles apart.
- R8: After `sense_off` and `filt_rst` are both released, the first window is discarded. `freq_bad` stays 0 for 2*WIN_CYC-1 reference cycles and shows the result of the second window after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | 125 MHz reference clock; all reference-domain logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| vco_clk | input | 1 | Recovered PLL clock that is measured |
| sense_off | input | 1 | 1 disables the monitor and forces the flag low |
| filt_rst | input | 1 | 1 while the PLL loop filter is in reset; forces the flag low |
| freq_bad | output | 1 | 1 when the last valid window was outside the band |

## Verification
The flag can be updated at a window end in the same cycle that a force input is raised. The force must win, so a pending bad result must never reach the output. To provoke this, the bench settles the VCO at a bad frequency so that the flag is high. It then raises `sense_off` or `filt_rst` at arbitrary points within the window and expects the flag to be low on the next sampled cycle. After release, the bench checks that the flag stays low across the discarded window and rises only after the second window. The checker also verifies that a rising flag never appears within 2*WIN_CYC cycles of a release.

// File: rtl/pll_freq_monitor.sv
module pll_freq_monitor #(
  parameter int WIN_CYC  = 1024,
  parameter int LO_LIM   = 1000,
  parameter int HI_LIM   = 1048,
  parameter int CNT_W    = 12,
  parameter int SYNC_STG = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic vco_clk,
  input  logic sense_off,
  input  logic filt_rst,
  output logic freq_bad
);
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_LIM);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_LIM);

  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // VCO domain: reset released synchronously, Gray-coded edge counter
  logic [1:0] vrst_q;
  always_ff @(posedge vco_clk or negedge rst_n)
    if (!rst_n) vrst_q <= '0;
    else        vrst_q <= {vrst_q[0], 1'b1};

  wire vco_rst_n = vrst_q[1];

  logic [CNT_W-1:0] vbin, vgray;
  wire  [CNT_W-1:0] vbin_nx = vbin + 1'b1;

  always_ff @(posedge vco_clk or negedge vco_rst_n)
    if (!vco_rst_n) begin
      vbin  <= '0;
      vgray <= '0;
    end else begin
      vbin  <= vbin_nx;
      vgray <= vbin_nx ^ (vbin_nx >> 1);
    end

  // Reference domain: synchronizer chain
  logic [CNT_W-1:0] sync_q [SYNC_STG];
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STG; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= vgray;
      for (int i = 1; i < SYNC_STG; i++) sync_q[i] <= sync_q[i-1];
    end

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] base_q;
  logic             skip_q;

  wire              hold     = sense_off | filt_rst;
  wire              win_end  = (win_q == WIN_LAST);
  wire [CNT_W-1:0]  cur_cnt  = gray_to_bin(sync_q[SYNC_STG-1]);
  wire [CNT_W-1:0]  span     = cur_cnt - base_q;
  wire              out_band = (span < LO_C) | (span > HI_C);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      win_q    <= '0;
      base_q   <= '0;
      skip_q   <= 1'b1;
      freq_bad <= 1'b0;
    end else if (hold) begin
      win_q    <= '0;
      base_q   <= cur_cnt;
      skip_q   <= 1'b1;
      freq_bad <= 1'b0;
    end else begin
      win_q <= win_end ? '0 : win_q + 1'b1;
      if (win_end) begin
        base_q <= cur_cnt;
        skip_q <= 1'b0;
        if (!skip_q) freq_bad <= out_band;
      end
    end
endmodule

// File: rtl/pll_freq_monitor_chk.sv
module pll_freq_monitor_chk #(
  parameter int WIN_CYC = 1024
) (
  input logic ref_clk,
  input logic rst_n,
  input logic sense_off,
  input logic filt_rst,
  input logic freq_bad
);
  localparam int GW = $clog2(2 * WIN_CYC) + 1;
  localparam logic [GW-1:0] RUN_MAX = GW'(2 * WIN_CYC);
  localparam logic [GW-1:0] GAP_MIN = GW'(WIN_CYC - 1);

  wire hold = sense_off | filt_rst;

  logic [GW-1:0] run_cnt, gap_cnt;
  logic          flag_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      run_cnt <= '0;
      gap_cnt <= '0;
      flag_q  <= 1'b0;
    end else begin
      flag_q  <= freq_bad;
      run_cnt <= hold ? '0 : (run_cnt == RUN_MAX ? run_cnt : run_cnt + 1'b1);
      gap_cnt <= (freq_bad != flag_q) ? '0 :
                 (gap_cnt == RUN_MAX ? gap_cnt : gap_cnt + 1'b1);
    end

  // R1
  always @(posedge ref_clk)
    if (!rst_n) reset_low_chk: assert (!freq_bad);

  // R5
  sense_force_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sense_off |=> !freq_bad);

  // R6
  filter_force_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    filt_rst |=> !freq_bad);

  // R8
  discard_first_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(freq_bad) |-> run_cnt >= RUN_MAX);

  // R7
  rise_spacing_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(freq_bad) |-> gap_cnt >= GAP_MIN);

  // R7
  fall_spacing_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($fell(freq_bad) && !$past(hold)) |-> gap_cnt >= GAP_MIN);
endmodule

bind pll_freq_monitor pll_freq_monitor_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .sense_off(sense_off),
  .filt_rst (filt_rst),
  .freq_bad (freq_bad)
);

// File: tb/tb_pll_freq_monitor.sv
module tb_pll_freq_monitor;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN = 1024;
  localparam int LO  = 1000;
  localparam int HI  = 1048;

  logic ref_clk = 1'b0, vco_clk = 1'b0;
  logic rst_n = 1'b0, sense_off = 1'b0, filt_rst = 1'b0;
  logic freq_bad;
  real  vco_half = 4.0;
  int   per_ps = 8000;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  pll_freq_monitor dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .vco_clk(vco_clk),
    .sense_off(sense_off), .filt_rst(filt_rst), .freq_bad(freq_bad)
  );

  always #4 ref_clk = ~ref_clk;
  initial forever #(vco_half) vco_clk = ~vco_clk;

  function automatic bit exp_bad(input int p);
    int cnt;
    cnt = (WIN * 8000) / p;
    return (cnt < LO) || (cnt > HI);
  endfunction

  task automatic set_per(input int p);
    per_ps   = p;
    vco_half = p / 2000.0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: freq_bad=%b expected=%b (period %0d ps)", req, act, exp, per_ps);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic string tag_of(input int p);
    int cnt;
    cnt = (WIN * 8000) / p;
    if (cnt < LO) return "R2";
    if (cnt > HI) return "R3";
    return "R4";
  endfunction

  initial begin
    #(200000 * 8);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    set_per(9000);
    cyc(5);
    chk("R1 reset", freq_bad, 1'b0);
    rst_n = 1'b1;
    cyc(1500);
    chk("R1 first window after reset discarded", freq_bad, 1'b0);
    cyc(1600);
    chk("R2 low band 111 MHz", freq_bad, 1'b1);

    set_per(8000);
    cyc(3100);
    chk("R4 centre 125 MHz", freq_bad, 1'b0);

    set_per(7000);
    cyc(3100);
    chk("R3 high band 143 MHz", freq_bad, 1'b1);

    // R5: force while flag high, at an arbitrary window phase
    cyc(317);
    sense_off = 1'b1;
    cyc(1);
    chk("R5 sense_off forces low", freq_bad, 1'b0);
    cyc(2500);
    chk("R5 held low while disabled", freq_bad, 1'b0);
    sense_off = 1'b0;
    cyc(1500);
    chk("R8 discard after sense_off release", freq_bad, 1'b0);
    cyc(700);
    chk("R8 second window reports", freq_bad, 1'b1);

    // R6: filter reset, low frequency
    set_per(9500);
    cyc(3100);
    chk("R2 low band 105 MHz", freq_bad, 1'b1);
    cyc(611);
    filt_rst = 1'b1;
    cyc(1);
    chk("R6 filt_rst forces low", freq_bad, 1'b0);
    cyc(1800);
    chk("R6 held low while filter reset", freq_bad, 1'b0);
    filt_rst = 1'b0;
    cyc(2000);
    chk("R8 discard after filt_rst release", freq_bad, 1'b0);
    cyc(200);
    chk("R8 second window after filt_rst", freq_bad, 1'b1);

    // R7: frequency toggled faster than the window
    begin
      int changes = 0;
      logic last = freq_bad;
      for (int k = 0; k < 2000; k++) begin
        if (k % 300 == 0) set_per(((k / 300) % 2) ? 8000 : 9000);
        cyc(1);
        if (freq_bad !== last) changes++;
        last = freq_bad;
      end
      n_run++;
      if (changes > 2) begin
        n_fail++;
        $display("FAIL R7: %0d flag changes in 2000 cycles, expected at most 2", changes);
      end
    end

    // Random frequencies away from the band edges
    for (int t = 0; t < 16; t++) begin
      int cls = $urandom_range(2, 0);
      int p;
      if (cls == 0)      p = $urandom_range(10000, 8300);
      else if (cls == 1) p = $urandom_range(7750, 6000);
      else               p = $urandom_range(8130, 7870);
      set_per(p);
      if (t % 5 == 4) begin
        cyc($urandom_range(900, 1));
        sense_off = 1'b1;
        cyc(1);
        chk("R5 random force", freq_bad, 1'b0);
        sense_off = 1'b0;
      end
      cyc(3100);
      chk(tag_of(p), freq_bad, exp_bad(p));
    end

    finish_run();
  end
endmodule